// File: doc/BRIEF.md
# Differential Clock Output Enable and Mode Sequencer

This block controls a small group of differential clock outputs and the operating mode of the clock path that feeds them. For each output it combines an active-low enable pin with a software enable bit. The combined enable is synchronized and applied only while the output clock sits low. When an output is disabled, both of its legs are driven low. When it is enabled, the true leg follows the reference clock level and the complement leg follows its inverse.

A power-good input sequences the block. The first time it rises, the block captures the decoded tri-level mode pins and starts up. When the mode is not bypass, the outputs stay blocked until the loop reports lock. Pulling power-good low enters power-down: all outputs go low and the loop is powered off. A later rise restarts the start-up sequence without capturing the mode pins again.

Software can override the mode and the frequency selection, but only when the matching override enable bit is set. The captured pin mode is always available for readback. Bypass mode powers the loop off and lets the outputs run without waiting for lock.

Top module: `clkctl_top`

## Requirements
- R1: While the sequencer is running, output g is enabled exactly when its software bit `sw_oe[g]` is 1 and its pin `oe_pin_n[g]` is 0. A pin value of 1 disables the output, and a software bit of 0 disables it whatever the pin says.
- R2: A disabled output drives `dif_p` = 0 and `dif_n` = 0. An enabled output drives `dif_p` equal to the registered reference level and `dif_n` equal to its inverse. The two legs are never high together.
- R3: With the reference level held low, a pin change reaches `out_en` on the third rising clock edge after it is applied, which is SYNC_STAGES+1 edges. A software enable bit change reaches `out_en` on the first edge.
- R4: `out_en` changes only at edges where `ref_lvl` is 0. While `ref_lvl` is held at 1, the enables keep their previous value.
- R5: After reset and before the first power-good assertion, every output is off, `loop_pd` is 1 and `mode_rb` reads 01.
- R6: The first high level on `pg_pin` captures `mode_pin` into `mode_rb`. Later power-good assertions do not capture it again.
- R7: In a loop mode (code 00 or 11), outputs stay off and `loop_pd` stays 0 until `pll_lock` is seen high after power-up.
- R8: `mode_sel` equals `sw_mode` when `sw_mode_en` is 1, and the captured pin mode otherwise. The codes are 00 for low bandwidth, 01 for bypass and 11 for high bandwidth. Code 10 is treated as bypass.
- R9: When the selected mode is bypass, `loop_pd` is 1 and the outputs start without lock.
- R10: `fsel` equals `sw_fsel` when `sw_fsel_en` is 1, and 00 otherwise.
- R11: When `pg_pin` goes low after start-up, all outputs turn off and `loop_pd` becomes 1. A later high level restarts the sequence, including the wait for lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_pin_n | input | N_OUT | Per-output enable pins, active low, asynchronous |
| pg_pin | input | 1 | Power-good / power-down pin, asynchronous |
| mode_pin | input | 2 | Decoded tri-level mode pin |
| pll_lock | input | 1 | Loop lock indication, asynchronous |
| sw_oe | input | N_OUT | Software output enable bits |
| sw_mode_en | input | 1 | Software mode override enable |
| sw_mode | input | 2 | Software mode code |
| sw_fsel_en | input | 1 | Software frequency select enable |
| sw_fsel | input | 2 | Software frequency select code |
| ref_lvl | input | 1 | Current level of the output reference clock |
| dif_p | output | N_OUT | True legs of the outputs |
| dif_n | output | N_OUT | Complement legs of the outputs |
| out_en | output | N_OUT | Gated per-output enables |
| mode_sel | output | 2 | Selected mode code |
| fsel | output | 2 | Effective frequency select |
| loop_pd | output | 1 | Loop power-down |
| mode_rb | output | 2 | Captured pin mode readback |

## Verification
The bench builds the block with N_OUT = 2 and SYNC_STAGES = 2. With two outputs, a random pin and software pattern can enable one output while the other stays off, which shows that the outputs are gated independently. With two synchronizer stages, the pin-to-enable latency is exactly three edges, so the bench can check the cycle before and the cycle of the change. The same settings keep short enough for the power-down and restart sequences, in both loop and bypass modes, to run several times within the cycle budget.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'b00,
    SEQ_WAIT  = 2'b01,
    SEQ_RUN   = 2'b10,
    SEQ_PDOWN = 2'b11
  } seq_state_t;

  localparam logic [1:0] MODE_LOBW  = 2'b00;
  localparam logic [1:0] MODE_BYP   = 2'b01;
  localparam logic [1:0] MODE_HIBW  = 2'b11;
  localparam logic [1:0] MODE_RESET = MODE_BYP;
  localparam logic [1:0] FSEL_DFLT  = 2'b00;

  // codes whose bits differ (01, 10) run the path in bypass
  function automatic logic mode_is_bypass(input logic [1:0] m);
    return m[1] ^ m[0];
  endfunction

endpackage

// File: rtl/clkctl_sync.sv
module clkctl_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/clkctl_seq.sv
module clkctl_seq
  import clkctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pg_s,
  input  logic       lock_s,
  input  logic [1:0] mode_pin,
  input  logic       sw_mode_en,
  input  logic [1:0] sw_mode,
  output logic       run_ok,
  output logic [1:0] mode_sel,
  output logic [1:0] mode_rb,
  output logic       loop_pd
);

  seq_state_t state_q, state_d;
  logic [1:0] mode_q, mode_d;
  logic       bypass;

  always_comb begin
    mode_sel = sw_mode_en ? sw_mode : mode_q;
    bypass   = mode_is_bypass(mode_sel);
  end

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (pg_s) begin
          mode_d  = mode_pin;
          state_d = SEQ_WAIT;
        end
      end
      SEQ_WAIT: begin
        if (!pg_s)                 state_d = SEQ_PDOWN;
        else if (lock_s || bypass) state_d = SEQ_RUN;
      end
      SEQ_RUN: begin
        if (!pg_s) state_d = SEQ_PDOWN;
      end
      SEQ_PDOWN: begin
        if (pg_s) state_d = SEQ_WAIT;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      mode_q  <= MODE_RESET;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
    end
  end

  always_comb begin
    run_ok  = (state_q == SEQ_RUN);
    mode_rb = mode_q;
    loop_pd = (state_q == SEQ_IDLE) || (state_q == SEQ_PDOWN) || bypass;
  end

  // R6
  mode_capture_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SEQ_IDLE) |=> $stable(mode_q));

  // R7
  lock_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_WAIT && !lock_s && !bypass) |=> (state_q != SEQ_RUN));

  // R11
  pg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg_s && (state_q == SEQ_RUN || state_q == SEQ_WAIT)) |=> (state_q == SEQ_PDOWN));

endmodule

// File: rtl/clkctl_gate.sv
module clkctl_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic ref_lvl,
  output logic en,
  output logic dif_p,
  output logic dif_n
);

  logic ref_q;
  logic en_q, en_d;

  // the enable moves only at an edge that leaves the true leg low
  always_comb begin
    en_d = en_q;
    if (!ref_lvl) en_d = want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      ref_q <= ref_lvl;
      en_q  <= en_d;
    end
  end

  always_comb begin
    en    = en_q;
    dif_p = en_q & ref_q;
    dif_n = en_q & ~ref_q;
  end

  // R4
  en_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> !ref_q);

  // R2
  legs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dif_p && dif_n));

  // R2
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!dif_p && !dif_n));

endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int N_OUT = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] oe_pin_n,
  input  logic             pg_pin,
  input  logic [1:0]       mode_pin,
  input  logic             pll_lock,
  input  logic [N_OUT-1:0] sw_oe,
  input  logic             sw_mode_en,
  input  logic [1:0]       sw_mode,
  input  logic             sw_fsel_en,
  input  logic [1:0]       sw_fsel,
  input  logic             ref_lvl,
  output logic [N_OUT-1:0] dif_p,
  output logic [N_OUT-1:0] dif_n,
  output logic [N_OUT-1:0] out_en,
  output logic [1:0]       mode_sel,
  output logic [1:0]       fsel,
  output logic             loop_pd,
  output logic [1:0]       mode_rb
);

  localparam logic [N_OUT-1:0] OE_OFF = '1;

  logic [N_OUT-1:0] oe_n_s;
  logic [1:0]       ctl_s;
  logic             run_ok;
  logic [N_OUT-1:0] want;

  clkctl_sync #(.W(N_OUT), .STAGES(SYNC_STAGES), .RST_VAL(OE_OFF)) u_oe_sync (
    .clk(clk), .rst_n(rst_n), .d(oe_pin_n), .q(oe_n_s)
  );

  clkctl_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({pll_lock, pg_pin}), .q(ctl_s)
  );

  clkctl_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .pg_s(ctl_s[0]), .lock_s(ctl_s[1]),
    .mode_pin(mode_pin), .sw_mode_en(sw_mode_en), .sw_mode(sw_mode),
    .run_ok(run_ok), .mode_sel(mode_sel), .mode_rb(mode_rb), .loop_pd(loop_pd)
  );

  always_comb fsel = sw_fsel_en ? sw_fsel : FSEL_DFLT;

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    always_comb want[g] = run_ok & sw_oe[g] & ~oe_n_s[g];

    clkctl_gate u_gate (
      .clk(clk), .rst_n(rst_n), .want(want[g]), .ref_lvl(ref_lvl),
      .en(out_en[g]), .dif_p(dif_p[g]), .dif_n(dif_n[g])
    );

    // R1
    en_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_en[g]) |-> $past(run_ok));
  end

endmodule

// File: tb/tb_clkctl_top.sv
module tb_clkctl_top;

  localparam int N = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] oe_pin_n, sw_oe;
  logic pg_pin, pll_lock, sw_mode_en, sw_fsel_en, ref_lvl;
  logic [1:0] mode_pin, sw_mode, sw_fsel;
  logic [N-1:0] dif_p, dif_n, out_en;
  logic [1:0] mode_sel, fsel, mode_rb;
  logic loop_pd;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  clkctl_top #(.N_OUT(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .oe_pin_n(oe_pin_n), .pg_pin(pg_pin),
    .mode_pin(mode_pin), .pll_lock(pll_lock), .sw_oe(sw_oe),
    .sw_mode_en(sw_mode_en), .sw_mode(sw_mode), .sw_fsel_en(sw_fsel_en),
    .sw_fsel(sw_fsel), .ref_lvl(ref_lvl), .dif_p(dif_p), .dif_n(dif_n),
    .out_en(out_en), .mode_sel(mode_sel), .fsel(fsel), .loop_pd(loop_pd),
    .mode_rb(mode_rb)
  );

  function automatic logic [N-1:0] exp_en(input logic [N-1:0] pin_n, input logic [N-1:0] sw);
    return sw & ~pin_n;
  endfunction

  function automatic logic [1:0] exp_mode(input logic en, input logic [1:0] sw, input logic [1:0] latched);
    return en ? sw : latched;
  endfunction

  function automatic logic exp_byp(input logic [1:0] m);
    return m[0] ^ m[1];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance n rising edges, land 1 ns after the last one
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(5ns * 100000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [N-1:0] prev;
    void'($urandom(32'h1c0d));
    rst_n = 1'b0; oe_pin_n = '0; sw_oe = '1; pg_pin = 1'b0; pll_lock = 1'b0;
    mode_pin = 2'b00; sw_mode_en = 1'b0; sw_mode = 2'b00; sw_fsel_en = 1'b0;
    sw_fsel = 2'b00; ref_lvl = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(8);
    // R5 reset state, no power-good yet
    chk("R5 out_en", out_en, '0);
    chk("R5 loop_pd", loop_pd, 1);
    chk("R5 mode_rb", mode_rb, 2'b01);
    chk("R5 legs", {dif_p, dif_n}, '0);

    // R7 first power-good in low-bandwidth loop mode, no lock
    pg_pin = 1'b1;
    step(12);
    chk("R7 blocked out_en", out_en, '0);
    chk("R7 loop running", loop_pd, 0);
    chk("R6 mode_rb captured", mode_rb, 2'b00);
    chk("R8 mode_sel from pin", mode_sel, 2'b00);
    pll_lock = 1'b1;
    step(8);
    chk("R7 out_en after lock", out_en, 2'b11);

    // R3 pin latency with ref held low
    oe_pin_n = 2'b01;
    step(2);
    chk("R3 before latency", out_en, 2'b11);
    step(1);
    chk("R3 at latency", out_en, 2'b10);
    // R3 software bit latency
    sw_oe = 2'b01;
    step(1);
    chk("R3 sw bit one edge", out_en, 2'b00);
    sw_oe = 2'b11; oe_pin_n = 2'b00;
    step(5);
    chk("R1 both on", out_en, 2'b11);

    // R4 hold while reference is high
    ref_lvl = 1'b1;
    sw_oe = 2'b00;
    step(4);
    chk("R4 held while ref high", out_en, 2'b11);
    // R2 legs with ref high
    chk("R2 true legs high", dif_p, 2'b11);
    chk("R2 comp legs low", dif_n, 2'b00);
    ref_lvl = 1'b0;
    step(1);
    chk("R4 applied when ref low", out_en, 2'b00);
    chk("R2 disabled legs low", {dif_p, dif_n}, '0);
    sw_oe = 2'b10;
    step(1);
    chk("R2 comp leg follows", dif_n, 2'b10);
    chk("R2 true leg low", dif_p, 2'b00);

    // R1 R8 R9 R10 random patterns
    for (int i = 0; i < 40; i++) begin
      oe_pin_n = N'($urandom());
      sw_oe = N'($urandom());
      sw_mode_en = 1'($urandom());
      sw_mode = 2'($urandom());
      sw_fsel_en = 1'($urandom());
      sw_fsel = 2'($urandom());
      step(4);
      chk("R1 random out_en", out_en, exp_en(oe_pin_n, sw_oe));
      chk("R8 random mode_sel", mode_sel, exp_mode(sw_mode_en, sw_mode, 2'b00));
      chk("R9 random loop_pd", loop_pd, exp_byp(exp_mode(sw_mode_en, sw_mode, 2'b00)));
      chk("R10 random fsel", fsel, sw_fsel_en ? sw_fsel : 2'b00);
    end

    // R10 directed: select ignored while disabled
    sw_fsel_en = 1'b0; sw_fsel = 2'b11;
    step(1);
    chk("R10 fsel default", fsel, 2'b00);
    // R8 reserved code acts as bypass
    sw_mode_en = 1'b1; sw_mode = 2'b10;
    step(1);
    chk("R8 reserved code bypass", loop_pd, 1);

    // R11 power-down
    sw_mode_en = 1'b0; sw_oe = 2'b11; oe_pin_n = 2'b00;
    step(5);
    prev = out_en;
    chk("R1 on before power-down", prev, 2'b11);
    pg_pin = 1'b0;
    step(6);
    chk("R11 outputs off", out_en, '0);
    chk("R11 loop_pd", loop_pd, 1);
    mode_pin = 2'b11;
    pg_pin = 1'b1;
    step(8);
    chk("R6 no recapture", mode_rb, 2'b00);
    chk("R11 restart with lock", out_en, 2'b11);

    // R11 restart waits for lock again; R9 bypass starts without lock
    pg_pin = 1'b0;
    step(6);
    pll_lock = 1'b0;
    pg_pin = 1'b1;
    step(12);
    chk("R11 restart blocked", out_en, '0);
    chk("R7 loop on while waiting", loop_pd, 0);
    sw_mode_en = 1'b1; sw_mode = 2'b01;
    step(6);
    chk("R9 bypass loop_pd", loop_pd, 1);
    chk("R9 bypass runs unlocked", out_en, 2'b11);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule